// File: doc/BRIEF.md
# Divider-Driven Timer with Delayed Reload

This peripheral holds a free-running 16-bit divider that advances on every machine-cycle tick. A speed code in the control register picks one divider bit. That bit is ANDed with the control enable bit. Each falling edge of the result bumps an 8-bit counter. The edge is seen whether the fall comes from the divider counting, from a divider clear, or from a change to the enable or speed code.

When the counter steps past 0xFF it reads 0x00 for a short window. At the end of the window it is loaded from the modulo register, and the interrupt flag is raised in that same tick. A processor write to the counter early in the window keeps the written value and cancels both the reload and the interrupt. A write in the reload cycle itself is dropped. The processor reaches four byte registers through a 2-bit offset. It can also set or clear the interrupt flag directly.

Top module: `divtick_timer`

## Requirements
- R1: After reset the divider, counter and modulo read 0x00, the control register reads 0xF8 and the interrupt flag is 0.
- R2: The divider increments by one on every cycle with `tickEn` high and wraps after 0xFFFF. Offset 0 reads its upper byte. Any write to offset 0 clears all 16 bits.
- R3: Control bit 2 is the enable. Control bits [1:0] select divider bit 9, 3, 5 or 7 for codes 0, 1, 2 and 3. Each high-to-low change of (selected bit AND enable) increments the counter at offset 1. While the enable is 0 the counter does not move.
- R4: A fall of that AND result caused by a divider clear or by a control write also increments the counter.
- R5: When the counter increments from 0xFF it reads 0x00 for the next four ticks. On the fifth tick after the wrap it takes the modulo value, and the interrupt flag is set in that same tick.
- R6: A counter write within the first four ticks after a wrap stores the written value. The pending reload and interrupt are then cancelled.
- R7: A counter write after the fourth tick following a wrap, before the reload tick completes, is ignored.
- R8: `irqWrEn` sets the interrupt flag to `irqWrVal` regardless of the overflow logic.
- R9: Reads of the control register at offset 3 return bits [7:3] as 1 and bits [2:0] as written. The modulo register at offset 2 reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Machine-cycle tick enable |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register offset: 0 divider, 1 counter, 2 modulo, 3 control |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| irqWrEn | input | 1 | Direct interrupt flag write strobe |
| irqWrVal | input | 1 | Value for the direct flag write |
| irqFlag | output | 1 | Interrupt request flag |

## Verification
The hardest state to reach is the window after a wrap, because a counter write has to land on an exact tick inside it. The bench loads the counter with 0xFE and uses the fastest speed code, so the wrap falls on a known tick count. It then sweeps the write through every position in the window and at the reload tick. At each position it checks the counter value and the interrupt flag against the outcome it expects. Divider-clear and enable-drop edges are produced by parking the divider with the selected bit high.

// File: rtl/divtick_pkg.sv
package divtick_pkg;
  localparam int unsigned DivW      = 16;
  localparam int unsigned CntW      = 8;
  localparam int unsigned OvfTicks  = 4;
  localparam int unsigned StepW     = $clog2(OvfTicks + 1);
  localparam int unsigned SpeedBit [4] = '{9, 3, 5, 7};

  localparam logic [1:0] RegDiv  = 2'd0;
  localparam logic [1:0] RegCnt  = 2'd1;
  localparam logic [1:0] RegMod  = 2'd2;
  localparam logic [1:0] RegCtrl = 2'd3;

  typedef struct packed {
    logic incCount;    // counter increments this cycle
    logic reload;      // counter loads modulo and flag is set
    logic cntWrAllow;  // processor write to counter is honoured
  } tmrStrobe_t;
endpackage

// File: rtl/divtick_ctrl.sv
module divtick_ctrl
  import divtick_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic       andNext,
  input  logic       cntFull,
  input  logic       modFull,
  output tmrStrobe_t st
);
  logic andReg, andValid;
  logic ovfActive, aborted;
  logic [StepW-1:0] step;
  logic cntWr, fallEdge, atLast, reloadTick, wrapNow;

  assign cntWr      = wrEn && (addr == RegCnt);
  assign fallEdge   = andValid && andReg && !andNext;
  assign atLast     = ovfActive && (step == StepW'(OvfTicks));
  assign reloadTick = tickEn && atLast;

  always_comb begin
    st.reload     = reloadTick && !aborted;
    st.cntWrAllow = !atLast;
    st.incCount   = fallEdge && !(cntWr && st.cntWrAllow);
  end

  assign wrapNow = st.reload ? modFull : cntFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      andReg   <= 1'b0;
      andValid <= 1'b0;
    end else begin
      andReg <= andNext;
      if (tickEn) andValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfActive <= 1'b0;
      aborted   <= 1'b0;
      step      <= '0;
    end else begin
      if (tickEn && ovfActive) begin
        if (step < StepW'(OvfTicks)) step <= step + 1'b1;
        else begin
          ovfActive <= 1'b0;
          aborted   <= 1'b0;
        end
      end
      if (cntWr && ovfActive && (step < StepW'(OvfTicks))) aborted <= 1'b1;
      if (st.incCount && wrapNow) begin
        ovfActive <= 1'b1;
        aborted   <= 1'b0;
        step      <= '0;
      end
    end
  end

  assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovfActive |-> (step <= StepW'(OvfTicks)));
  assert_window_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.incCount && wrapNow) |=> (ovfActive && step == '0 && !aborted));
  assert_abort_latch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cntWr && ovfActive && step < StepW'(OvfTicks)) |=> aborted);
endmodule

// File: rtl/divtick_dp.sv
module divtick_dp
  import divtick_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            tickEn,
  input  logic            wrEn,
  input  logic [1:0]      addr,
  input  logic [CntW-1:0] wrData,
  input  logic            irqWrEn,
  input  logic            irqWrVal,
  input  tmrStrobe_t      st,
  output logic            andNext,
  output logic            cntFull,
  output logic            modFull,
  output logic [CntW-1:0] rdData,
  output logic            irqFlag
);
  logic [DivW-1:0] divReg, divNext;
  logic [2:0]      ctrlReg, ctrlNext;
  logic [CntW-1:0] cntReg, cntBase, cntNext, modReg;
  logic divWr, cntWr, modWr, ctrlWr;

  assign divWr  = wrEn && (addr == RegDiv);
  assign cntWr  = wrEn && (addr == RegCnt);
  assign modWr  = wrEn && (addr == RegMod);
  assign ctrlWr = wrEn && (addr == RegCtrl);

  always_comb begin
    if (divWr)       divNext = '0;
    else if (tickEn) divNext = divReg + 1'b1;
    else             divNext = divReg;
    ctrlNext = ctrlWr ? wrData[2:0] : ctrlReg;
    andNext  = divNext[SpeedBit[ctrlNext[1:0]]] && ctrlNext[2];
  end

  assign cntFull = (cntReg == '1);
  assign modFull = (modReg == '1);

  always_comb begin
    cntBase = st.reload ? modReg : cntReg;
    if (cntWr && st.cntWrAllow) cntNext = wrData;
    else if (st.incCount)       cntNext = cntBase + 1'b1;
    else                        cntNext = cntBase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= '0;
      ctrlReg <= '0;
      cntReg  <= '0;
      modReg  <= '0;
      irqFlag <= 1'b0;
    end else begin
      divReg  <= divNext;
      ctrlReg <= ctrlNext;
      cntReg  <= cntNext;
      if (modWr) modReg <= wrData;
      if (st.reload)    irqFlag <= 1'b1;
      else if (irqWrEn) irqFlag <= irqWrVal;
    end
  end

  always_comb begin
    unique case (addr)
      RegDiv:  rdData = divReg[DivW-1 -: CntW];
      RegCnt:  rdData = cntReg;
      RegMod:  rdData = modReg;
      default: rdData = {{(CntW-3){1'b1}}, ctrlReg};
    endcase
  end

  assert_div_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    divWr |=> (divReg == '0));
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.incCount && !st.reload && cntReg == '1 && !cntWr) |=> (cntReg == '0));
  assert_reload_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.reload && !st.incCount && !(cntWr && st.cntWrAllow)) |=> (cntReg == $past(modReg)));
  assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.reload |=> irqFlag);
  assert_ignored_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cntWr && !st.cntWrAllow && !st.incCount && !st.reload) |=> $stable(cntReg));
endmodule

// File: rtl/divtick_timer.sv
module divtick_timer
  import divtick_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       irqWrEn,
  input  logic       irqWrVal,
  output logic       irqFlag
);
  tmrStrobe_t st;
  logic andNext, cntFull, modFull;

  divtick_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .andNext(andNext), .cntFull(cntFull), .modFull(modFull), .st(st)
  );

  divtick_dp u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .irqWrEn(irqWrEn), .irqWrVal(irqWrVal), .st(st),
    .andNext(andNext), .cntFull(cntFull), .modFull(modFull),
    .rdData(rdData), .irqFlag(irqFlag)
  );
endmodule

// File: tb/divtick_timer_bench.sv
`timescale 1ns/1ps
module divtick_timer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, wrEn = 1'b0, irqWrEn = 1'b0, irqWrVal = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic irqFlag;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  divtick_timer u_divtick_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqWrEn(irqWrEn), .irqWrVal(irqWrVal),
    .irqFlag(irqFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic checkReg(input string req, input logic [1:0] a, input int exp);
    logic [7:0] v;
    readReg(a, v);
    check(req, v, exp);
  endtask

  // Counter FE, modulo 42, speed code 1, then 32 ticks: wrap on the last tick
  task automatic toWrap();
    doReset();
    writeReg(2'd2, 8'h42);
    writeReg(2'd1, 8'hFE);
    writeReg(2'd3, 8'h05);
    tick(16);
    checkReg("R3", 2'd1, 8'hFF);
    tick(16);
  endtask

  initial begin
    doReset();
    // R1 reset state
    checkReg("R1", 2'd0, 0);
    checkReg("R1", 2'd1, 0);
    checkReg("R1", 2'd2, 0);
    checkReg("R1", 2'd3, 8'hF8);
    check("R1", irqFlag, 0);

    // R9 read-back
    writeReg(2'd2, 8'hA5);
    checkReg("R9", 2'd2, 8'hA5);
    writeReg(2'd3, 8'h05);
    checkReg("R9", 2'd3, 8'hFD);

    // R2 divider counting, clear, wrap
    doReset();
    tick(300);
    checkReg("R2", 2'd0, 300 >> 8);
    writeReg(2'd0, 8'h77);
    checkReg("R2", 2'd0, 0);
    tick(65536 + 700);
    checkReg("R2", 2'd0, 700 >> 8);

    // R3 speed sweep: expected increments = ticks >> (bit+1)
    for (int code = 0; code < 4; code++) begin
      int bitPos, n;
      bitPos = (code == 0) ? 9 : (code == 1) ? 3 : (code == 2) ? 5 : 7;
      n = 3 * (1 << (bitPos + 1)) + 1;
      doReset();
      writeReg(2'd3, 8'(4 | code));
      tick(n);
      checkReg("R3", 2'd1, n >> (bitPos + 1));
      tick((1 << bitPos) - 2);
      checkReg("R3", 2'd1, n >> (bitPos + 1));
    end
    // R3 disabled: no movement
    doReset();
    writeReg(2'd3, 8'h01);
    tick(200);
    checkReg("R3", 2'd1, 0);

    // R4 divider clear with selected bit high
    doReset();
    writeReg(2'd3, 8'h05);
    tick(8);
    checkReg("R4", 2'd1, 0);
    writeReg(2'd0, 8'h00);
    checkReg("R4", 2'd1, 1);
    // R4 enable drop with selected bit high
    tick(8);
    writeReg(2'd3, 8'h01);
    checkReg("R4", 2'd1, 2);
    tick(100);
    checkReg("R4", 2'd1, 2);

    // R5 window then reload
    toWrap();
    checkReg("R5", 2'd1, 0);
    for (int i = 1; i <= 4; i++) begin
      tick(1);
      checkReg("R5", 2'd1, 0);
      check("R5", irqFlag, 0);
    end
    tick(1);
    checkReg("R5", 2'd1, 8'h42);
    check("R5", irqFlag, 1);

    // R6 abort at every early position
    for (int j = 0; j < 4; j++) begin
      toWrap();
      tick(j);
      writeReg(2'd1, 8'h10);
      checkReg("R6", 2'd1, 8'h10);
      tick(10);
      checkReg("R6", 2'd1, 8'h10);
      check("R6", irqFlag, 0);
    end

    // R7 write at the last window position is dropped
    toWrap();
    tick(4);
    writeReg(2'd1, 8'h10);
    checkReg("R7", 2'd1, 0);
    tick(1);
    checkReg("R7", 2'd1, 8'h42);
    check("R7", irqFlag, 1);

    // R8 direct flag control
    irqWrVal = 1'b0; irqWrEn = 1'b1;
    @(negedge clk); irqWrEn = 1'b0;
    check("R8", irqFlag, 0);
    irqWrVal = 1'b1; irqWrEn = 1'b1;
    @(negedge clk); irqWrEn = 1'b0;
    check("R8", irqFlag, 1);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule